// File: doc/BRIEF.md
# Start-up Latency Repeatability Meter

This block measures, in link clock cycles, how long a serial receive link takes from the release of its active-low synchronization request to the first valid user data word at the receiver output. It is used while the receiver is reset again and again. Each new measurement is compared with the one taken just before it. A flag is raised when the two differ by more than a tolerance that is driven on an input pin. The usual tolerance is 1, because word alignment can move control characters one cycle later and so lengthen the alignment phase by one clock.

The meter has three phases. It waits for the request to be asserted. It then waits for the request to be released. From that release it counts until the first valid word arrives. The count register stops at its maximum value. A run that reaches that value without seeing valid data ends with a timeout flag and no result.

Top module: `lat_repeat_meter`

## Requirements
- R1: While reset is low and directly after it, `cur_count`, `prev_count`, `done`, `mismatch` and `timeout` are all 0.
- R2: The release is sampled high at clock edge E0. If `data_valid` is first sampled high at edge E0+k, with k >= 1, then k is captured into `cur_count`. The value of `data_valid` at E0 itself is ignored.
- R3: `done` is high for exactly one cycle, the cycle after the capture edge. Two captures are never closer than this.
- R4: On a capture, `prev_count` takes the value that `cur_count` held before the capture.
- R5: The first capture after reset never sets `mismatch`.
- R6: On every later capture, `mismatch` is set to 1 when |new − old `cur_count`| is greater than `tol`, and to 0 when it is less than or equal to `tol`.
- R7: `mismatch` keeps its value between captures.
- R8: The count register stops at 2^CNT_W−1. With the default CNT_W of 10, a run still counting at edge E0+1023 without valid data sets `timeout`. It gives no `done` and leaves `cur_count` and `prev_count` unchanged. Valid data at exactly E0+1023 is captured as 1023 and does not set `timeout`.
- R9: After a capture or a timeout, valid data and a request held high are ignored until the request is asserted low and released again.
- R10: While the request is low, `data_valid` is ignored. Asserting the request during a count aborts the run, and this takes priority over valid data in the same cycle.
- R11: `timeout` clears at the next release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_n | input | 1 | Active-low synchronization request; 1 = released |
| data_valid | input | 1 | Receiver output carries valid user data |
| tol | input | TOL_W | Allowed run-to-run difference in cycles |
| cur_count | output | CNT_W | Latest captured latency |
| prev_count | output | CNT_W | Latency captured before the latest one |
| done | output | 1 | One-cycle strobe after a capture |
| mismatch | output | 1 | Latest latency differs from the previous one by more than `tol` |
| timeout | output | 1 | Last run reached the count limit without valid data |

## Verification
Two events can arrive in the same cycle while counting. Valid data can arrive on the very edge where the count reaches its limit. The request can be asserted again in the same cycle that valid data appears. The bench sets up both cases. In the first, valid data at exactly E0+1023 must give a capture of 1023 with `done` and no timeout, while a run one cycle longer must give a timeout and no strobe. In the second, the abort must win: no strobe appears and the next run's count starts again from its own release.

// File: rtl/lat_meter_pkg.sv
package lat_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_COUNT = 2'd2
  } lat_state_e;
endpackage

// File: rtl/lat_arm_fsm.sv
module lat_arm_fsm
  import lat_meter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic data_valid,
  input  logic sat,
  output logic start,
  output logic capture,
  output logic expire,
  output logic counting
);
  lat_state_e state_q, state_d;

  assign counting = (state_q == ST_COUNT);
  assign start    = (state_q == ST_REQ) && sync_n;
  assign capture  = counting && sync_n && data_valid;
  assign expire   = counting && sync_n && !data_valid && sat;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (!sync_n) state_d = ST_REQ;
      ST_REQ:   if (sync_n) state_d = ST_COUNT;
      ST_COUNT: begin
        if (!sync_n) state_d = ST_REQ;
        else if (capture || expire) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9
  rearm_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture || expire) |=> !counting);

  // R10
  abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !sync_n) |=> (state_q == ST_REQ));
endmodule

// File: rtl/lat_counter.sv
module lat_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             counting,
  input  logic             expire,
  output logic [CNT_W-1:0] cnt,
  output logic             sat,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             to_q, to_d, to_en;

  assign sat     = (cnt_q == CNT_MAX);
  assign cnt     = cnt_q;
  assign timeout = to_q;

  always_comb begin
    cnt_en = start || (counting && !sat);
    cnt_d  = start ? CNT_ONE : (cnt_q + CNT_ONE);
    to_en  = start || expire;
    to_d   = !start && expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (to_en)  to_q  <= to_d;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && sat && !start) |=> (cnt_q == CNT_MAX));

  // R11
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !to_q);
endmodule

// File: rtl/lat_compare.sv
module lat_compare #(
  parameter int CNT_W = 10,
  parameter int TOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CNT_W-1:0] cnt,
  input  logic [TOL_W-1:0] tol,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] prev_count,
  output logic             done,
  output logic             mismatch
);
  logic [CNT_W-1:0] cur_q, prev_q, diff;
  logic             have_q, mm_q, mm_d, done_q;

  always_comb begin
    diff = (cnt >= cur_q) ? (cnt - cur_q) : (cur_q - cnt);
    mm_d = have_q && (diff > CNT_W'(tol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      have_q <= 1'b0;
      mm_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= capture;
      if (capture) begin
        prev_q <= cur_q;
        cur_q  <= cnt;
        mm_q   <= mm_d;
        have_q <= 1'b1;
      end
    end
  end

  assign cur_count  = cur_q;
  assign prev_count = prev_q;
  assign done       = done_q;
  assign mismatch   = mm_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4
  prev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (prev_q == $past(cur_q)));

  // R5
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !have_q) |=> !mm_q);

  // R7
  mm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(mm_q));
endmodule

// File: rtl/lat_repeat_meter.sv
module lat_repeat_meter #(
  parameter int CNT_W = 10,
  parameter int TOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             data_valid,
  input  logic [TOL_W-1:0] tol,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] prev_count,
  output logic             done,
  output logic             mismatch,
  output logic             timeout
);
  logic             start, capture, expire, counting, sat;
  logic [CNT_W-1:0] cnt;

  lat_arm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n     (sync_n),
    .data_valid (data_valid),
    .sat        (sat),
    .start      (start),
    .capture    (capture),
    .expire     (expire),
    .counting   (counting)
  );

  lat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .counting (counting),
    .expire   (expire),
    .cnt      (cnt),
    .sat      (sat),
    .timeout  (timeout)
  );

  lat_compare #(.CNT_W(CNT_W), .TOL_W(TOL_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .cnt        (cnt),
    .tol        (tol),
    .cur_count  (cur_count),
    .prev_count (prev_count),
    .done       (done),
    .mismatch   (mismatch)
  );

  // R8
  timeout_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!done && $stable(cur_count)));
endmodule

// File: tb/lat_repeat_meter_bench.sv
`timescale 1ns/1ps
module lat_repeat_meter_bench;
  localparam int CNT_W = 10;
  localparam int TOL_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_n = 1'b0;
  logic             data_valid = 1'b0;
  logic [TOL_W-1:0] tol = 4'd1;
  logic [CNT_W-1:0] cur_count, prev_count;
  logic             done, mismatch, timeout;

  int n_tests = 0;
  int n_fail  = 0;
  int done_seen = 0;
  int base;

  always #5 clk = ~clk;

  lat_repeat_meter #(.CNT_W(CNT_W), .TOL_W(TOL_W)) u_lat_repeat_meter (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .data_valid(data_valid),
    .tol(tol), .cur_count(cur_count), .prev_count(prev_count),
    .done(done), .mismatch(mismatch), .timeout(timeout)
  );

  always @(negedge clk) if (done) done_seen++;

  // columns: latency k, tol, expected cur, expected prev, expected mismatch
  localparam int VEC [0:7][0:4] = '{
    '{131, 1, 131,   0, 0},
    '{132, 1, 132, 131, 0},
    '{131, 1, 131, 132, 0},
    '{133, 1, 133, 131, 1},
    '{133, 0, 133, 133, 0},
    '{130, 2, 130, 133, 1},
    '{132, 2, 132, 130, 0},
    '{  5, 0,   5, 132, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // request low for two cycles, release, valid sampled at E0+k
  task automatic measure(input int k);
    sync_n = 1'b0; data_valid = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    repeat (k) @(negedge clk);
    data_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cur", int'(cur_count), 0);
    chk("R1 prev", int'(prev_count), 0);
    chk("R1 flags", int'({done, mismatch, timeout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({done, mismatch, timeout}), 0);

    for (int i = 0; i < 8; i++) begin
      tol = TOL_W'(VEC[i][1]);
      measure(VEC[i][0]);
      chk("R2 count", int'(cur_count), VEC[i][2]);
      chk("R4 prev", int'(prev_count), VEC[i][3]);
      chk("R6 mismatch", int'(mismatch), VEC[i][4]);
      chk("R3 done high", int'(done), 1);
      data_valid = 1'b0;
      @(negedge clk);
      chk("R3 done single", int'(done), 0);
      chk("R7 mismatch hold", int'(mismatch), VEC[i][4]);
    end

    // R9: valid pulses with request held released are ignored
    base = done_seen;
    data_valid = 1'b1;
    repeat (4) @(negedge clk);
    data_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no done", done_seen - base, 0);
    chk("R9 cur kept", int'(cur_count), 5);

    // R10: valid while request low is ignored; count runs from release
    tol = 4'd15;
    sync_n = 1'b0; data_valid = 1'b1;
    base = done_seen;
    repeat (4) @(negedge clk);
    chk("R10 no done while low", done_seen - base, 0);
    data_valid = 1'b0; sync_n = 1'b1;
    repeat (10) @(negedge clk);
    data_valid = 1'b1;
    @(negedge clk);
    chk("R10 count from release", int'(cur_count), 10);
    data_valid = 1'b0;

    // R10: abort in same cycle as valid wins
    measure(1);
    data_valid = 1'b0;
    @(negedge clk);
    sync_n = 1'b0; data_valid = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    repeat (20) @(negedge clk);
    base = done_seen;
    sync_n = 1'b0; data_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 abort beats valid", done_seen - base, 0);
    chk("R10 cur after abort", int'(cur_count), 1);
    measure(40);
    chk("R10 restart count", int'(cur_count), 40);
    data_valid = 1'b0;

    // R8: timeout after limit
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    base = done_seen;
    repeat (1100) @(negedge clk);
    chk("R8 timeout set", int'(timeout), 1);
    chk("R8 no done", done_seen - base, 0);
    chk("R8 cur kept", int'(cur_count), 40);
    chk("R8 prev kept", int'(prev_count), 1);

    // R11 clear on release, R8 boundary capture at limit
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 timeout held while low", int'(timeout), 1);
    sync_n = 1'b1;
    @(negedge clk);
    chk("R11 timeout cleared", int'(timeout), 0);
    repeat (1022) @(negedge clk);
    data_valid = 1'b1;
    @(negedge clk);
    chk("R8 capture at limit", int'(cur_count), 1023);
    chk("R8 done at limit", int'(done), 1);
    chk("R8 no timeout at limit", int'(timeout), 0);
    data_valid = 1'b0;

    // R5: reset mid-run, first capture never mismatches
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears cur", int'(cur_count), 0);
    rst_n = 1'b1;
    tol = 4'd0;
    measure(500);
    chk("R5 first capture", int'(cur_count), 500);
    chk("R5 no mismatch", int'(mismatch), 0);
    chk("R5 prev zero", int'(prev_count), 0);
    data_valid = 1'b0;
    measure(501);
    chk("R6 over tol zero", int'(mismatch), 1);
    data_valid = 1'b0;

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule